// File: doc/BRIEF.md
# Self-Correcting Codeword Register

This block is a small register file of flip-flops that keeps one codeword of a regular low-density parity-check code. It is meant to be valid at all times even though single bits may flip for one cycle. On every clock edge that is not a load, the register takes a corrected copy of its own contents. Each bit is set by a majority vote among estimates of that bit. Each estimate comes from one parity check that the bit belongs to, computed from the other bits of that check only. A transient flip therefore never reaches the register output.

The code is built from a prime `P`. The `N = P*P` bits sit on a `P x P` grid at index `a*P + b`. Each of `J` groups holds `P` checks, and every check is a line through the grid with slope equal to its group number. Any two checks from different groups share exactly one bit, and checks in the same group share none. Because of this, one flipped bit can spoil at most one estimate of any other bit. `J` must be even, so the vote has an odd number of inputs and cannot tie. A load strobe writes a word straight into the register. A fault mask models transient flips of the stored bits within the cycle. A status output reports a non-zero syndrome before correction.

Top module: `stab_mem`

## Requirements
- R1: While reset is asserted, and after it is released with no load and a zero mask, `word_o` is all zeros and `synd_err_o` is 0.
- R2: When `wr_en` is 1 at a rising edge, `word_o` after that edge equals `wr_word` exactly. Neither correction nor `flip_mask` affects the loaded value.
- R3: Bit `a*P+b` belongs to check `s` of group `g` (0 <= g < J) exactly when `(b + g*a) mod P == s`. So every bit is in J checks and every check covers P bits. Any word flips the same number of bits, mod 2, in every group.
- R4: With `wr_en` low, a zero mask and `synd_err_o` low, `word_o` does not change at the next edge.
- R5: When `word_o` holds a codeword and `flip_mask` has exactly one bit set, at any position, `word_o` after the edge equals the same codeword.
- R6: `synd_err_o` is combinational. It is 1 exactly when some check has odd parity over `word_o ^ flip_mask`.
- R7: The next value of each bit is the majority of J-1 estimates, taken from groups 0 to J-2. Each estimate is the XOR of the other P-1 bits of that check. For example, a word with a single bit set goes to all zeros in one cycle.
- R8: Correction leaves any codeword unchanged. This holds even when the codeword is formed by `word_o ^ flip_mask` with a mask that is itself a codeword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load strobe; bypasses correction |
| wr_word | input | P*P | Word to load |
| flip_mask | input | P*P | Transient bit flips applied to the stored word this cycle |
| word_o | output | P*P | Corrected stored word |
| synd_err_o | output | 1 | Some check of the flipped word has odd parity |

## Verification
Single-bit faults are walked through all 25 positions on top of one codeword. This shows that every bit's vote uses the right checks, and that no neighbour is pulled along by a bad estimate. Back-to-back faults on a second codeword from a different family show that repair happens in the same cycle as the fault. A mask that is itself a codeword separates correction from plain restoration: the result must be the XOR of the two words, with no error flag. A loaded word of weight one separates the load bypass (kept for one cycle) from the vote (cleared the cycle after). An all-ones mask during a load must raise the flag yet leave the loaded word untouched.

// File: rtl/stab_mem_pkg.sv
package stab_mem_pkg;
  // Check slot of bit idx inside group grp on a p x p grid.
  function automatic int grid_slot(input int idx, input int grp, input int p);
    return ((idx % p) + grp * (idx / p)) % p;
  endfunction
endpackage

// File: rtl/stab_parity_net.sv
module stab_parity_net
  import stab_mem_pkg::*;
#(
  parameter int P = 5,
  parameter int J = 4
) (
  input  logic [P*P-1:0] word_i,
  output logic [J*P-1:0] syn_o
);
  localparam int N = P * P;

  for (genvar g = 0; g < J; g++) begin : g_grp
    for (genvar s = 0; s < P; s++) begin : g_chk
      logic acc;
      always_comb begin
        acc = 1'b0;
        for (int i = 0; i < N; i++) begin
          if (grid_slot(i, g, P) == s) acc = acc ^ word_i[i];
        end
      end
      assign syn_o[g*P+s] = acc;
    end
    if (g > 0) begin : g_sum_chk
      // R3: each group partitions all bits, so group parities agree
      always_comb begin
        p_group_sum_r3: assert (^syn_o[0 +: P] == ^syn_o[g*P +: P]);
      end
    end
  end
endmodule

// File: rtl/stab_bit_vote.sv
module stab_bit_vote
  import stab_mem_pkg::*;
#(
  parameter int P   = 5,
  parameter int J   = 4,
  parameter int IDX = 0
) (
  input  logic           own_i,
  input  logic [J*P-1:0] syn_i,
  output logic           nxt_o
);
  localparam int NV   = J - 1;
  localparam int HALF = NV / 2;

  logic [NV-1:0] est;
  logic [$clog2(NV+1)-1:0] ones;

  for (genvar g = 0; g < NV; g++) begin : g_est
    localparam int SLOT = grid_slot(IDX, g, P);
    // full check parity with own bit removed = XOR of the other bits
    assign est[g] = syn_i[g*P+SLOT] ^ own_i;
  end

  always_comb begin
    ones = '0;
    for (int v = 0; v < NV; v++) ones = ones + {{($clog2(NV+1)-1){1'b0}}, est[v]};
    nxt_o = (int'(ones) > HALF);
  end

  // R7: unanimous estimates equal to the own bit keep it
  always_comb begin
    if (est == {NV{own_i}}) p_agree_keep_r7: assert (nxt_o == own_i);
  end
endmodule

// File: rtl/stab_mem.sv
module stab_mem #(
  parameter int P = 5,
  parameter int J = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [P*P-1:0] wr_word,
  input  logic [P*P-1:0] flip_mask,
  output logic [P*P-1:0] word_o,
  output logic           synd_err_o
);
  localparam int N    = P * P;
  localparam int NCHK = J * P;

  logic [N-1:0]    word_q;
  logic [N-1:0]    seen;
  logic [N-1:0]    fixed;
  logic [N-1:0]    word_d;
  logic [NCHK-1:0] syn;

  assign seen = word_q ^ flip_mask;

  stab_parity_net #(.P(P), .J(J)) u_par (
    .word_i (seen),
    .syn_o  (syn)
  );

  for (genvar i = 0; i < N; i++) begin : g_bit
    stab_bit_vote #(.P(P), .J(J), .IDX(i)) u_vote (
      .own_i (seen[i]),
      .syn_i (syn),
      .nxt_o (fixed[i])
    );
  end

  always_comb begin
    word_d = wr_en ? wr_word : fixed;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= word_d;
  end

  assign word_o     = word_q;
  assign synd_err_o = |syn;

  // R2: load lands unchanged
  p_load_exact_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> word_o == $past(wr_word));

  // R4: quiet cycle on a clean word holds it
  p_hold_clean_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && flip_mask == '0 && !synd_err_o) |=> $stable(word_o));
endmodule

// File: tb/sim_stab_mem.sv
module sim_stab_mem;
  localparam int P = 5;
  localparam int J = 4;
  localparam int N = P * P;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [N-1:0] wr_word;
  logic [N-1:0] flip_mask;
  logic [N-1:0] word_o;
  logic         synd_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct { logic [N-1:0] w; string tag; } exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  stab_mem #(.P(P), .J(J)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_word(wr_word),
    .flip_mask(flip_mask), .word_o(word_o), .synd_err_o(synd_err_o)
  );

  // two columns a0, a1 of the grid: every sloped line meets each once
  function automatic logic [N-1:0] col_pair(int a0, int a1);
    logic [N-1:0] r = '0;
    for (int b = 0; b < P; b++) begin
      r[a0*P+b] = 1'b1;
      r[a1*P+b] = 1'b1;
    end
    return r;
  endfunction

  // two parallel lines of slope 4 (a group not used, since J=4)
  function automatic logic [N-1:0] slope4_pair(int s0, int s1);
    logic [N-1:0] r = '0;
    for (int a = 0; a < P; a++)
      for (int b = 0; b < P; b++)
        if ((b + 4*a) % P == s0 || (b + 4*a) % P == s1) r[a*P+b] = 1'b1;
    return r;
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: synd_err_o=%0b expected %0b", tag, act, exp);
    end
  endtask

  // driver: apply one cycle, check flag, push expected word
  task automatic step(logic w, logic [N-1:0] wd, logic [N-1:0] fm,
                      logic [N-1:0] expw, logic experr, string tw, string te);
    exp_t e;
    @(negedge clk);
    wr_en = w; wr_word = wd; flip_mask = fm;
    #1;
    check_bit(te, synd_err_o, experr);
    e.w = expw; e.tag = tw;
    sb_q.push_back(e);
  endtask

  // monitor: compare after each edge
  always @(posedge clk) begin
    #2;
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      n_chk++;
      if (word_o !== e.w) begin
        n_fail++;
        $display("FAIL %s: word_o=%h expected %h", e.tag, word_o, e.w);
      end
    end
  end

  initial begin
    logic [N-1:0] cw_a, cw_b, cw_c, one12;
    cw_a  = col_pair(1, 3);
    cw_b  = slope4_pair(0, 2);
    cw_c  = col_pair(0, 4);
    one12 = '0; one12[12] = 1'b1;
    rst_n = 1'b0; wr_en = 1'b0; wr_word = '0; flip_mask = '0;
    repeat (3) @(negedge clk);
    n_chk++;
    if (word_o !== '0) begin n_fail++; $display("FAIL R1: word_o=%h expected 0", word_o); end
    rst_n = 1'b1;
    @(negedge clk);
    n_chk++;
    if (word_o !== '0) begin n_fail++; $display("FAIL R1: word_o=%h expected 0", word_o); end
    check_bit("R1 flag", synd_err_o, 1'b0);

    step(1'b0, '0, '0, '0, 1'b0, "R4 idle zero", "R6 idle zero");
    // load with all-ones mask: mask ignored, but flag sees odd checks
    step(1'b1, cw_a, '1, cw_a, 1'b1, "R2 load ignores mask", "R6 all-ones mask");
    step(1'b0, '0, '0, cw_a, 1'b0, "R4 hold codeword", "R6 clean codeword");
    for (int k = 0; k < N; k++) begin
      logic [N-1:0] m;
      m = '0; m[k] = 1'b1;
      step(1'b0, '0, m, cw_a, 1'b1, $sformatf("R5 flip bit %0d", k),
           $sformatf("R6 flip bit %0d", k));
    end
    step(1'b1, cw_b, '0, cw_b, 1'b0, "R2 load second codeword", "R6 before load");
    for (int k = 3; k < N; k += 7) begin
      logic [N-1:0] m;
      m = '0; m[k] = 1'b1;
      step(1'b0, '0, m, cw_b, 1'b1, $sformatf("R5 back-to-back bit %0d", k), "R6 back-to-back");
    end
    step(1'b0, '0, cw_c, cw_b ^ cw_c, 1'b0, "R8 codeword mask kept", "R6 codeword mask");
    step(1'b0, '0, '0, cw_b ^ cw_c, 1'b0, "R8 hold sum", "R6 sum clean");
    step(1'b1, one12, '0, one12, 1'b0, "R2 load weight-one", "R6 before weight-one");
    step(1'b0, '0, '0, '0, 1'b1, "R7 weight-one cleared", "R6 weight-one stored");
    step(1'b0, '0, '0, '0, 1'b0, "R4 zero after clear", "R6 zero after clear");
    @(negedge clk);
    wr_en = 1'b0; flip_mask = '0;
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule